// File: doc/BRIEF.md
# Bidirectional Ring Data Arbiter

This block decides which node of a ring interconnect may start a data transfer next, and on which ring. The interconnect has twelve nodes joined by four one-way rings. Rings 0 and 1 carry data clockwise, that is from node k towards node k+1. Rings 2 and 3 carry data counter-clockwise. Each ring moves 16 bytes per beat. The arbiter runs on the ring clock, which is half the core clock, so one arbiter cycle is one beat.

Every node can raise a request with a destination node and a length. The arbiter picks the shorter direction around the ring and works out which hops the transfer will cross. It then looks for a ring of that direction on which none of those hops is in use. Several transfers can share one ring at the same time, as long as their hop segments are disjoint, with at most three per ring. One node, the flow-controller-class requester, always wins when it can be placed. The other nodes are served in round-robin order.

A granted requester sees a one-cycle grant together with the ring id and direction. It must drop its request in the cycle the grant is shown. The arbiter frees the hops by itself once the transfer's beats have elapsed.

Top module: `ring_data_arb`

## Requirements
- R1: The direction is clockwise (dir_o=0) when (dst - src) mod 12 is at most 6, otherwise counter-clockwise (dir_o=1). Rings 0 and 1 are clockwise and rings 2 and 3 are counter-clockwise, so dir_o equals ring_o bit 1.
- R2: A grant uses the lowest-numbered ring of the chosen direction that can accept the transfer.
- R3: A clockwise transfer from s occupies the links s to s+1 and onward up to its destination; a counter-clockwise one occupies the links s to s-1 and onward. A transfer is placed on a ring only if none of its links is held by a live transfer on that ring, and transfers on disjoint links share a ring.
- R4: A ring holds at most three live transfers. A fourth transfer that is otherwise free of conflict goes to the other ring of its direction.
- R5: The length field L (len_i, 4 bits per node) holds the links for L+1 cycles. Requests sampled up to the (L+1)-th edge after the grant edge still see them busy, and a request sampled at the next edge sees them free.
- R6: A request that no ring can accept gets no grant and stays pending until it fits. It does not delay requests from other nodes that do fit.
- R7: Node PRIO (0 by default) is granted ahead of every other eligible request.
- R8: The other nodes are served round robin. The search starts at the node after the last round-robin winner, and the pointer moves only on a round-robin grant.
- R9: A request whose destination equals its own node, or is 12 or more, is never granted and does not block others.
- R10: At most one node is granted per cycle. grant_o is registered: it rises at the edge that samples the request and lasts one cycle. A node is not granted in the cycle its grant is shown.
- R11: While rst is high and in the cycle after it, grant_o is zero and no transfer is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring clock (half the core clock) |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 12 | Transfer request, one bit per node |
| dst_i | input | 48 | Destination node, 4 bits per node (node n at bits 4n+3..4n) |
| len_i | input | 48 | Beats minus one, 4 bits per node |
| grant_o | output | 12 | One-hot grant, held for one cycle |
| ring_o | output | 2 | Ring chosen for the granted transfer (0 when no grant) |
| dir_o | output | 1 | 0 clockwise, 1 counter-clockwise (0 when no grant) |

## Verification
The hardest state to reach is a pending request that is blocked on both rings of its direction, with another node placed alongside it in the same cycle. Reaching it requires several long transfers with overlapping hop sets, issued one after another, so that one ring is full by slot count and the other is full by link conflict. The bench builds this state in sequence, then raises the blocked request and an unrelated one together. It checks that only the unrelated one is granted, and that the blocked one is placed once the earliest transfer expires. The exact release edge is found with a short transfer followed by probes launched one cycle apart, which land on different rings.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;
  typedef enum logic {
    DIR_CW  = 1'b0,
    DIR_CCW = 1'b1
  } ring_dir_e;
endpackage

// File: rtl/ring_route.sv
module ring_route #(
  parameter int N      = 12,
  parameter int NODE_W = 4,
  parameter int SRC    = 0
) (
  input  logic [NODE_W-1:0] dst_i,
  output logic              ccw_o,
  output logic [N-1:0]      mask_o,
  output logic              ok_o
);
  int dcw;

  always_comb begin
    dcw    = (int'(dst_i) + N - SRC) % N;
    ok_o   = (int'(dst_i) < N) && (dcw != 0);
    ccw_o  = dcw > (N / 2);
    mask_o = '0;
    for (int k = 0; k < N; k++) begin
      if (!ccw_o && k < dcw)     mask_o[(SRC + k) % N] = 1'b1;
      if (ccw_o && k < N - dcw)  mask_o[(SRC - k + N) % N] = 1'b1;
    end
  end
endmodule

// File: rtl/ring_pick.sv
module ring_pick #(
  parameter int N      = 12,
  parameter int NODE_W = 4,
  parameter int PRIO   = 0
) (
  input  logic [N-1:0]      elig_i,
  input  logic [NODE_W-1:0] ptr_i,
  output logic [N-1:0]      gnt_o
);
  int  idx;
  logic found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    idx   = 0;
    if (elig_i[PRIO]) begin
      gnt_o[PRIO] = 1'b1;
    end else begin
      for (int k = 0; k < N; k++) begin
        idx = (int'(ptr_i) + k) % N;
        if (!found && idx != PRIO && elig_i[idx]) begin
          gnt_o[idx] = 1'b1;
          found      = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ring_slots.sv
module ring_slots #(
  parameter int N      = 12,
  parameter int RINGS  = 4,
  parameter int SLOTS  = 3,
  parameter int RING_W = 2,
  parameter int CNT_W  = 5
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 ld_i,
  input  logic [RING_W-1:0]                    ld_ring_i,
  input  logic [N-1:0]                         ld_mask_i,
  input  logic [CNT_W-1:0]                     ld_beats_i,
  output logic [RINGS-1:0][N-1:0]              occ_o,
  output logic [RINGS-1:0]                     free_o,
  output logic [RINGS-1:0][SLOTS-1:0][N-1:0]   slot_mask_o,
  output logic [RINGS-1:0][SLOTS-1:0]          slot_live_o
);
  logic [RINGS-1:0][SLOTS-1:0][N-1:0]     mask_q;
  logic [RINGS-1:0][SLOTS-1:0][CNT_W-1:0] cnt_q;
  logic [RINGS-1:0][SLOTS-1:0]            pick;

  always_comb begin
    occ_o = '0;
    free_o = '0;
    pick = '0;
    for (int r = 0; r < RINGS; r++) begin
      for (int s = 0; s < SLOTS; s++) begin
        slot_live_o[r][s] = cnt_q[r][s] != '0;
        slot_mask_o[r][s] = mask_q[r][s];
        if (cnt_q[r][s] != '0) begin
          occ_o[r] = occ_o[r] | mask_q[r][s];
        end else if (!free_o[r]) begin
          pick[r][s] = 1'b1;
          free_o[r]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      for (int r = 0; r < RINGS; r++) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (ld_i && ld_ring_i == RING_W'(r) && pick[r][s]) begin
            cnt_q[r][s]  <= ld_beats_i;
            mask_q[r][s] <= ld_mask_i;
          end else if (cnt_q[r][s] != '0) begin
            cnt_q[r][s] <= cnt_q[r][s] - CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ring_data_arb.sv
module ring_data_arb
  import ring_arb_pkg::*;
#(
  parameter int N      = 12,
  parameter int NODE_W = 4,
  parameter int LEN_W  = 4,
  parameter int RINGS  = 4,
  parameter int SLOTS  = 3,
  parameter int PRIO   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          req_i,
  input  logic [N*NODE_W-1:0]   dst_i,
  input  logic [N*LEN_W-1:0]    len_i,
  output logic [N-1:0]          grant_o,
  output logic [$clog2(RINGS)-1:0] ring_o,
  output logic                  dir_o
);
  localparam int RING_W = $clog2(RINGS);
  localparam int HALF   = RINGS / 2;
  localparam int CNT_W  = LEN_W + 1;

  logic [N-1:0]              route_ok, node_ccw, node_fit, elig, win, grant_q;
  logic [N-1:0][N-1:0]       node_mask;
  logic [N-1:0][RING_W-1:0]  node_ring;
  logic [RINGS-1:0][N-1:0]   occ;
  logic [RINGS-1:0]          ring_free;
  logic [RINGS-1:0][SLOTS-1:0][N-1:0] slot_mask_w;
  logic [RINGS-1:0][SLOTS-1:0]        slot_live_w;
  logic [NODE_W-1:0]         rr_ptr, sel_idx;
  logic [RING_W-1:0]         sel_ring, ring_q;
  logic [N-1:0]              sel_mask;
  logic [CNT_W-1:0]          sel_beats;
  logic                      any_win;
  ring_dir_e                 dir_q;

  for (genvar n = 0; n < N; n++) begin : g_node
    ring_route #(.N(N), .NODE_W(NODE_W), .SRC(n)) u_route (
      .dst_i  (dst_i[n*NODE_W +: NODE_W]),
      .ccw_o  (node_ccw[n]),
      .mask_o (node_mask[n]),
      .ok_o   (route_ok[n])
    );

    always_comb begin
      node_fit[n]  = 1'b0;
      node_ring[n] = '0;
      for (int h = HALF - 1; h >= 0; h--) begin
        if (ring_free[node_ccw[n] ? HALF + h : h] &&
            (occ[node_ccw[n] ? HALF + h : h] & node_mask[n]) == '0) begin
          node_fit[n]  = 1'b1;
          node_ring[n] = RING_W'(node_ccw[n] ? HALF + h : h);
        end
      end
    end

    assign elig[n] = req_i[n] & route_ok[n] & ~grant_q[n] & node_fit[n];
  end

  ring_pick #(.N(N), .NODE_W(NODE_W), .PRIO(PRIO)) u_pick (
    .elig_i (elig),
    .ptr_i  (rr_ptr),
    .gnt_o  (win)
  );

  always_comb begin
    sel_ring  = '0;
    sel_mask  = '0;
    sel_beats = '0;
    sel_idx   = '0;
    for (int n = 0; n < N; n++) begin
      if (win[n]) begin
        sel_ring  = node_ring[n];
        sel_mask  = node_mask[n];
        sel_beats = CNT_W'(len_i[n*LEN_W +: LEN_W]) + CNT_W'(1);
        sel_idx   = NODE_W'(n);
      end
    end
  end

  assign any_win = |win;

  ring_slots #(
    .N(N), .RINGS(RINGS), .SLOTS(SLOTS), .RING_W(RING_W), .CNT_W(CNT_W)
  ) u_slots (
    .clk         (clk),
    .rst         (rst),
    .ld_i        (any_win),
    .ld_ring_i   (sel_ring),
    .ld_mask_i   (sel_mask),
    .ld_beats_i  (sel_beats),
    .occ_o       (occ),
    .free_o      (ring_free),
    .slot_mask_o (slot_mask_w),
    .slot_live_o (slot_live_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      ring_q  <= '0;
      dir_q   <= DIR_CW;
      rr_ptr  <= '0;
    end else begin
      grant_q <= win;
      ring_q  <= any_win ? sel_ring : '0;
      dir_q   <= (any_win && sel_ring >= RING_W'(HALF)) ? DIR_CCW : DIR_CW;
      if (any_win && !win[PRIO]) begin
        rr_ptr <= (sel_idx == NODE_W'(N - 1)) ? '0 : sel_idx + NODE_W'(1);
      end
    end
  end

  assign grant_o = grant_q;
  assign ring_o  = ring_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/ring_data_arb_chk.sv
module ring_data_arb_chk #(
  parameter int N      = 12,
  parameter int NODE_W = 4,
  parameter int RINGS  = 4,
  parameter int SLOTS  = 3,
  parameter int RING_W = 2
) (
  input logic                               clk,
  input logic                               rst,
  input logic [N-1:0]                       req_i,
  input logic [N*NODE_W-1:0]                dst_i,
  input logic [N-1:0]                       grant_o,
  input logic [RING_W-1:0]                  ring_o,
  input logic                               dir_o,
  input logic [RINGS-1:0][SLOTS-1:0][N-1:0] slot_mask,
  input logic [RINGS-1:0][SLOTS-1:0]        slot_live
);
  localparam int HALF = RINGS / 2;

  p_onehot_grant_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  p_dir_ring_r1: assert property (@(posedge clk) disable iff (rst)
    (|grant_o) |-> (dir_o == (ring_o >= RING_W'(HALF))));

  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> (grant_o == '0 && slot_live == '0));

  for (genvar n = 0; n < N; n++) begin : g_n
    p_grant_had_req_r10: assert property (@(posedge clk) disable iff (rst)
      grant_o[n] |-> $past(req_i[n]));
    p_single_cycle_r10: assert property (@(posedge clk) disable iff (rst)
      grant_o[n] |=> !grant_o[n]);
    p_no_self_dest_r9: assert property (@(posedge clk) disable iff (rst)
      grant_o[n] |-> ($past(dst_i[n*NODE_W +: NODE_W]) != NODE_W'(n)));
  end

  for (genvar r = 0; r < RINGS; r++) begin : g_r
    for (genvar s = 0; s < SLOTS; s++) begin : g_s
      for (genvar t = s + 1; t < SLOTS; t++) begin : g_t
        p_disjoint_links_r3: assert property (@(posedge clk) disable iff (rst)
          (slot_live[r][s] && slot_live[r][t]) |->
            ((slot_mask[r][s] & slot_mask[r][t]) == '0));
      end
    end
  end
endmodule

bind ring_data_arb ring_data_arb_chk #(
  .N(N), .NODE_W(NODE_W), .RINGS(RINGS), .SLOTS(SLOTS), .RING_W(RING_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .dst_i     (dst_i),
  .grant_o   (grant_o),
  .ring_o    (ring_o),
  .dir_o     (dir_o),
  .slot_mask (slot_mask_w),
  .slot_live (slot_live_w)
);

// File: tb/ring_data_arb_tb_top.sv
module ring_data_arb_tb_top;
  localparam int N = 12;
  localparam int NV = 8;
  // fields: src[14:11] dst[10:7] len[6:3] dir[2] ring[1:0]
  localparam logic [14:0] VEC [NV] = '{
    {4'd0,  4'd3,  4'd2, 1'b0, 2'd0},
    {4'd0,  4'd6,  4'd1, 1'b0, 2'd0},
    {4'd0,  4'd7,  4'd0, 1'b1, 2'd2},
    {4'd5,  4'd4,  4'd3, 1'b1, 2'd2},
    {4'd11, 4'd0,  4'd0, 1'b0, 2'd0},
    {4'd3,  4'd9,  4'd4, 1'b0, 2'd0},
    {4'd9,  4'd3,  4'd1, 1'b0, 2'd0},
    {4'd2,  4'd9,  4'd5, 1'b1, 2'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   req = '0;
  logic [N*4-1:0] dst = '0;
  logic [N*4-1:0] len = '0;
  logic [N-1:0]   grant_o;
  logic [1:0]     ring_o;
  logic           dir_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ring_data_arb dut_i (
    .clk(clk), .rst(rst), .req_i(req), .dst_i(dst), .len_i(len),
    .grant_o(grant_o), .ring_o(ring_o), .dir_o(dir_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_req(input int n, input int d, input int l);
    dst[n*4 +: 4] = 4'(d);
    len[n*4 +: 4] = 4'(l);
    req[n] = 1'b1;
  endtask

  // raise a request, check the grant one negedge later, drop it
  task automatic issue(input int n, input int d, input int l, input int exp_ring, input string tag);
    @(negedge clk);
    set_req(n, d, l);
    @(negedge clk);
    chk(grant_o == N'(1 << n), tag, int'(grant_o), 1 << n);
    chk(int'(ring_o) == exp_ring, tag, int'(ring_o), exp_ring);
    req[n] = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int order [3];
    int got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(grant_o == '0, "R11 grant after reset", int'(grant_o), 0);
    chk(ring_o == '0 && dir_o == 1'b0, "R11 ring/dir after reset", int'(ring_o), 0);

    // table walk: R1 direction, R2 lowest ring, R10 latency
    for (int i = 0; i < NV; i++) begin
      int s, d, l;
      s = int'(VEC[i][14:11]);
      d = int'(VEC[i][10:7]);
      l = int'(VEC[i][6:3]);
      @(negedge clk);
      set_req(s, d, l);
      @(negedge clk);
      chk(grant_o == N'(1 << s), "R10 grant latency", int'(grant_o), 1 << s);
      chk(dir_o == VEC[i][2], "R1 direction", int'(dir_o), int'(VEC[i][2]));
      chk(ring_o == VEC[i][1:0], "R2 ring pick", int'(ring_o), int'(VEC[i][1:0]));
      req[s] = 1'b0;
      @(negedge clk);
      chk(grant_o == '0, "R10 one-cycle grant", int'(grant_o), 0);
      repeat (l + 3) @(negedge clk);
    end

    // R3 link conflicts and sharing, R6 pending
    settle();
    issue(1, 4, 15, 0, "R3 first on ring0");
    issue(2, 3, 15, 1, "R3 overlap moves to ring1");
    issue(3, 5, 15, 1, "R3 disjoint share ring1");
    issue(0, 1, 15, 0, "R3 disjoint share ring0");
    issue(6, 8, 15, 0, "R3 third on ring0");
    @(negedge clk);
    set_req(2, 4, 0);
    set_req(9, 10, 0);
    @(negedge clk);
    chk(grant_o == N'(1 << 9), "R6 other node not delayed", int'(grant_o), 1 << 9);
    chk(ring_o == 2'd1, "R4 ring0 full goes ring1", int'(ring_o), 1);
    req[9] = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(grant_o == '0, "R6 blocked stays pending", int'(grant_o), 0);
    end
    got = 0;
    for (int c = 0; c < 40 && got == 0; c++) begin
      @(negedge clk);
      if (grant_o[2]) begin
        got = 1;
        chk(ring_o == 2'd0, "R6 placed after release", int'(ring_o), 0);
      end
    end
    chk(got == 1, "R6 pending eventually granted", got, 1);
    req[2] = 1'b0;

    // R4 slot limit
    settle();
    issue(0, 1, 15, 0, "R4 slot a");
    issue(2, 3, 15, 0, "R4 slot b");
    issue(4, 5, 15, 0, "R4 slot c");
    issue(6, 7, 15, 1, "R4 fourth to ring1");

    // R7 priority
    settle();
    @(negedge clk);
    set_req(5, 6, 0);
    set_req(0, 2, 0);
    @(negedge clk);
    chk(grant_o == N'(1), "R7 priority first", int'(grant_o), 1);
    req[0] = 1'b0;
    @(negedge clk);
    chk(grant_o == N'(1 << 5), "R7 other next", int'(grant_o), 1 << 5);
    req[5] = 1'b0;

    // R8 round robin: pointer now 6
    settle();
    @(negedge clk);
    set_req(3, 4, 0);
    set_req(7, 8, 0);
    set_req(9, 10, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      order[k] = -1;
      for (int n = 0; n < N; n++) if (grant_o[n]) begin order[k] = n; req[n] = 1'b0; end
    end
    chk(order[0] == 7, "R8 rr first", order[0], 7);
    chk(order[1] == 9, "R8 rr second", order[1], 9);
    chk(order[2] == 3, "R8 rr wrap", order[2], 3);
    settle();
    @(negedge clk);
    set_req(3, 4, 0);
    set_req(9, 10, 0);
    @(negedge clk);
    chk(grant_o == N'(1 << 9), "R8 pointer after 3", int'(grant_o), 1 << 9);
    req[9] = 1'b0;
    @(negedge clk);
    chk(grant_o == N'(1 << 3), "R8 then 3", int'(grant_o), 1 << 3);
    req[3] = 1'b0;

    // R9 invalid destinations
    settle();
    @(negedge clk);
    set_req(4, 4, 0);
    set_req(8, 13, 0);
    repeat (5) begin
      @(negedge clk);
      chk(grant_o == '0, "R9 invalid dest not granted", int'(grant_o), 0);
    end
    set_req(6, 7, 0);
    @(negedge clk);
    chk(grant_o == N'(1 << 6), "R9 invalid does not block", int'(grant_o), 1 << 6);
    req = '0;

    // R5 release edge, probe sampled at third edge -> still busy
    settle();
    issue(1, 2, 2, 0, "R5 holder a");
    @(negedge clk);
    @(negedge clk);
    set_req(0, 2, 0);
    @(negedge clk);
    chk(grant_o == N'(1), "R5 probe granted", int'(grant_o), 1);
    chk(ring_o == 2'd1, "R5 link still busy", int'(ring_o), 1);
    req[0] = 1'b0;
    // probe sampled one edge later -> free
    settle();
    issue(1, 2, 2, 0, "R5 holder b");
    repeat (3) @(negedge clk);
    set_req(0, 2, 0);
    @(negedge clk);
    chk(ring_o == 2'd0, "R5 link released", int'(ring_o), 0);
    req[0] = 1'b0;

    // R11 reset mid-transfer
    @(negedge clk);
    set_req(5, 6, 15);
    @(negedge clk);
    req = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(grant_o == '0, "R11 reset clears grant", int'(grant_o), 0);
    issue(5, 6, 0, 0, "R11 links free after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule